// File: doc/BRIEF.md
# DMX512 Chase Frame Transmitter

This block drives one serial line with a continuous stream of DMX512 frames and produces the channel data itself. Each frame opens with a long low level that marks a new frame. A short high level follows, then a zero start code, then one byte for every slot, and the slots go out back to back. A fixed idle gap at mark level separates one frame from the next.

The slot data comes from a built-in chase generator. In every frame exactly one channel among the first CHASE_LEN channels carries full scale, and every other slot carries zero. The lit channel moves forward by one with each finished frame, so a chain of fixtures on the line lights up one after another. The only control input is a level enable, which is honoured at frame boundaries. A one-cycle pulse marks the end of each frame. The line driver and any host-supplied data lie outside the block.

All timings are counted in clock cycles. BIT_CYCLES is the bit period, which is 4 µs (250 kbaud) at the default 50 MHz. BREAK_CYCLES gives 100 µs, MAB_CYCLES gives 12 µs and GAP_CYCLES gives 25 ms. SLOTS defaults to 512.

Top module: `dmx_chase_tx`

## Requirements
- R1: After reset, and for as long as no frame has been started, tx_line is high (mark) and frame_done is low.
- R2: A frame begins with tx_line low for exactly BREAK_CYCLES cycles.
- R3: After the low period, tx_line stays high for exactly MAB_CYCLES cycles before the first start bit.
- R4: Each byte is sent as one low start bit, then 8 data bits with the least significant bit first, then two high stop bits. Every bit lasts BIT_CYCLES cycles. The next byte's start bit follows the previous byte's second stop bit with no idle time.
- R5: The first byte of each frame is the start code 0x00. It is followed by SLOTS channel bytes, with channel 1 first.
- R6: In each frame exactly one channel byte is 0xFF and all other channel bytes are 0x00. The first frame after reset lights channel 1.
- R7: The lit channel advances by one from each frame to the next, and wraps from channel CHASE_LEN back to channel 1.
- R8: frame_done is high for one cycle, in the cycle right after the second stop bit of the last slot ends. tx_line then stays high for GAP_CYCLES cycles counted from that cycle, and the next low period starts after them.
- R9: The enable is examined only when a frame may start. If enable is deasserted during a frame, that frame still completes in full. While enable is low no new frame starts and tx_line stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Level enable, examined at frame starts |
| tx_line | output | 1 | Serial DMX line, high is mark |
| frame_done | output | 1 | One-cycle pulse after the last slot |

## Verification
Two things happen in the same clock edge at the end of the last stop bit of the final slot. The frame-done pulse rises and the chase generator advances its lit channel, so the next frame's data must already show the new channel. The bench checks this in every frame, across 26 frames, which include the wrap from the last chase channel back to channel 1. A second coincidence occurs at every byte boundary inside a frame, where the end of one byte's stop bit is also the load of the next byte. Each start bit is sampled exactly one bit period after the previous stop bit, so any lost or added cycle there shows up as a decoding error. The enable is also dropped partway through the final frame, and the bench then checks that the frame finishes and that no new low period follows.

// File: rtl/dmx_tx_pkg.sv
package dmx_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BREAK,
    ST_MAB,
    ST_SLOT,
    ST_GAP
  } dmx_state_e;

  localparam logic [7:0] LEVEL_FULL = 8'hFF;
  localparam logic [7:0] LEVEL_OFF  = 8'h00;
  localparam int         BYTE_BITS  = 11;  // start + 8 data + 2 stop
endpackage

// File: rtl/dmx_bit_timer.sv
module dmx_bit_timer #(
  parameter int BIT_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = (BIT_CYCLES > 1) ? $clog2(BIT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(BIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clear)  cnt_q <= '0;
    else if (run)    cnt_q <= tick ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/dmx_byte_ser.sv
module dmx_byte_ser
  import dmx_tx_pkg::*;
#(
  parameter int BIT_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] data,
  output logic       line_bit,
  output logic       busy,
  output logic       last_tick
);
  logic [BYTE_BITS-1:0] sh_q;
  logic [3:0]           left_q;
  logic                 busy_q;
  logic                 tick;

  dmx_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (load),
    .run   (busy_q),
    .tick  (tick)
  );

  assign busy      = busy_q;
  assign last_tick = busy_q && tick && (left_q == 4'd1);
  assign line_bit  = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (load) begin
      sh_q   <= {2'b11, data, 1'b0};
      left_q <= 4'(BYTE_BITS);
      busy_q <= 1'b1;
    end else if (busy_q && tick) begin
      sh_q   <= {1'b1, sh_q[BYTE_BITS-1:1]};
      left_q <= left_q - 4'd1;
      if (left_q == 4'd1) busy_q <= 1'b0;
    end
  end

  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (!busy_q || last_tick)); // R4
  AST_STOP_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && left_q <= 4'd2) |-> line_bit); // R4
endmodule

// File: rtl/dmx_chase_gen.sv
module dmx_chase_gen
  import dmx_tx_pkg::*;
#(
  parameter int CHASE_LEN = 24,
  parameter int SL_W      = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic [SL_W-1:0] slot_idx,
  output logic [7:0]      level
);
  localparam int AC_W = $clog2(CHASE_LEN + 1);
  localparam logic [AC_W-1:0] ACT_MAX = AC_W'(CHASE_LEN);

  logic [AC_W-1:0] active_q;
  logic [SL_W-1:0] active_ext;

  assign active_ext = SL_W'(active_q);
  assign level = (slot_idx != '0 && slot_idx == active_ext) ? LEVEL_FULL : LEVEL_OFF;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       active_q <= AC_W'(1);
    else if (advance) active_q <= (active_q == ACT_MAX) ? AC_W'(1) : active_q + 1'b1;
  end

  AST_ACTIVE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q >= AC_W'(1)) && (active_q <= ACT_MAX)); // R7
  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> $stable(active_q)); // R7
endmodule

// File: rtl/dmx_chase_tx.sv
module dmx_chase_tx
  import dmx_tx_pkg::*;
#(
  parameter int BIT_CYCLES   = 200,
  parameter int BREAK_CYCLES = 5000,
  parameter int MAB_CYCLES   = 600,
  parameter int GAP_CYCLES   = 1250000,
  parameter int SLOTS        = 512,
  parameter int CHASE_LEN    = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tx_line,
  output logic frame_done
);
  localparam int MAX_A  = (BREAK_CYCLES > MAB_CYCLES) ? BREAK_CYCLES : MAB_CYCLES;
  localparam int MAX_PH = (MAX_A > GAP_CYCLES) ? MAX_A : GAP_CYCLES;
  localparam int PH_W   = $clog2(MAX_PH + 1);
  localparam int SL_W   = $clog2(SLOTS + 1);
  localparam logic [PH_W-1:0] BRK_LAST = PH_W'(BREAK_CYCLES - 1);
  localparam logic [PH_W-1:0] MAB_LAST = PH_W'(MAB_CYCLES - 1);
  localparam logic [PH_W-1:0] GAP_LAST = PH_W'(GAP_CYCLES - 1);
  localparam logic [SL_W-1:0] SLOT_END = SL_W'(SLOTS);

  dmx_state_e      state_q, state_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic [SL_W-1:0] slot_q, slot_d, load_idx;
  logic            done_q, done_d;
  logic            ser_load, ser_bit, ser_busy, ser_last;
  logic [7:0]      level;

  dmx_chase_gen #(.CHASE_LEN(CHASE_LEN), .SL_W(SL_W)) u_chase (
    .clk      (clk),
    .rst_n    (rst_n),
    .advance  (done_d),
    .slot_idx (load_idx),
    .level    (level)
  );

  dmx_byte_ser #(.BIT_CYCLES(BIT_CYCLES)) u_ser (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (ser_load),
    .data      (level),
    .line_bit  (ser_bit),
    .busy      (ser_busy),
    .last_tick (ser_last)
  );

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q + 1'b1;
    slot_d   = slot_q;
    load_idx = slot_q + 1'b1;
    ser_load = 1'b0;
    done_d   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        phase_d = '0;
        if (enable) state_d = ST_BREAK;
      end
      ST_BREAK: begin
        if (phase_q == BRK_LAST) begin
          state_d = ST_MAB;
          phase_d = '0;
        end
      end
      ST_MAB: begin
        if (phase_q == MAB_LAST) begin
          state_d  = ST_SLOT;
          phase_d  = '0;
          slot_d   = '0;
          load_idx = '0;
          ser_load = 1'b1;
        end
      end
      ST_SLOT: begin
        phase_d = '0;
        if (ser_last) begin
          if (slot_q == SLOT_END) begin
            state_d = ST_GAP;
            done_d  = 1'b1;
          end else begin
            slot_d   = slot_q + 1'b1;
            ser_load = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (phase_q == GAP_LAST) begin
          phase_d = '0;
          state_d = enable ? ST_BREAK : ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      slot_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      slot_q  <= slot_d;
      done_q  <= done_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_BREAK: tx_line = 1'b0;
      ST_SLOT:  tx_line = ser_bit;
      default:  tx_line = 1'b1;
    endcase
  end

  assign frame_done = done_q;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done); // R8
  AST_FALL_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_line) |-> (state_q == ST_BREAK || state_q == ST_SLOT)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !enable) |=> (state_q == ST_IDLE)); // R9
  AST_SLOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SLOT) |-> ser_busy); // R4
endmodule

// File: tb/dmx_chase_tx_test.sv
module dmx_chase_tx_test;
  localparam int BITC = 4;
  localparam int BRK  = 20;
  localparam int MAB  = 8;
  localparam int GAP  = 40;
  localparam int NSL  = 32;
  localparam int CHL  = 24;
  localparam int NF   = 26;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic tx_line, frame_done;

  int checks = 0;
  int errors = 0;
  int frames_seen = -1;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  dmx_chase_tx #(
    .BIT_CYCLES(BITC), .BREAK_CYCLES(BRK), .MAB_CYCLES(MAB),
    .GAP_CYCLES(GAP), .SLOTS(NSL), .CHASE_LEN(CHL)
  ) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .tx_line(tx_line), .frame_done(frame_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic push_frame(input int lit);
    exp_q.push_back(8'h00);
    for (int c = 1; c <= NSL; c++) exp_q.push_back((c == lit) ? 8'hFF : 8'h00);
  endtask

  task automatic rx_byte(input int f, input int s);
    logic [7:0] got;
    logic [7:0] exp;
    string req;
    repeat (BITC / 2) @(negedge clk);
    check(tx_line == 1'b0, "R4 start bit", tx_line, 0);
    for (int b = 0; b < 8; b++) begin
      repeat (BITC) @(negedge clk);
      got[b] = tx_line;
    end
    for (int k = 0; k < 2; k++) begin
      repeat (BITC) @(negedge clk);
      check(tx_line == 1'b1, "R4 stop bit", tx_line, 1);
    end
    exp = exp_q.pop_front();
    req = (s == 0) ? "R5" : ((f >= CHL) ? "R7" : "R6");
    check(got == exp, req, got, exp);
    repeat (BITC - BITC / 2) @(negedge clk);
  endtask

  // driver
  initial begin
    for (int f = 0; f < NF; f++) push_frame((f % CHL) + 1);
    repeat (3) @(negedge clk);
    check(tx_line == 1'b1, "R1 line in reset", tx_line, 1);
    rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check(tx_line == 1'b1, "R1 line while disabled", tx_line, 1);
    check(frame_done == 1'b0, "R1 done while disabled", frame_done, 0);
    enable = 1'b1;
    wait (frames_seen == NF - 1);
    repeat (100) @(negedge clk);
    enable = 1'b0;
  end

  // monitor
  initial begin
    int n;
    @(posedge rst_n);
    @(negedge clk);
    while (tx_line) @(negedge clk);
    for (int f = 0; f < NF; f++) begin
      n = 0;
      while (!tx_line) begin n++; @(negedge clk); end
      check(n == BRK, "R2 break length", n, BRK);
      n = 0;
      while (tx_line && n < 10 * MAB) begin n++; @(negedge clk); end
      check(n == MAB, "R3 mark after break", n, MAB);
      frames_seen = f;
      for (int s = 0; s <= NSL; s++) rx_byte(f, s);
      check(frame_done == 1'b1, "R8 frame_done pulse", frame_done, 1);
      @(negedge clk);
      check(frame_done == 1'b0, "R8 pulse width", frame_done, 0);
      n = 1;
      if (f < NF - 1) begin
        while (tx_line && n < 10 * GAP) begin n++; @(negedge clk); end
        check(n == GAP, "R8 gap length", n, GAP);
      end else begin
        while (tx_line && n < 5 * GAP) begin n++; @(negedge clk); end
        check(n == 5 * GAP, "R9 no frame after disable", n, 5 * GAP);
      end
    end
    check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule